// File: doc/BRIEF.md
# Servo Amplifier Enable and Fault Latch

This block decides when a servo power amplifier may run. A servo controller asks for the amplifier with a level request. The block starts the amplifier on the rising edge of that request, and only if no fault condition is present at that moment. Several protection inputs can force a latched fault. When a fault latches, the run enable output drops at once so that the power stage shuts down.

The fault sources are these:
- the controller's processor reset, held low;
- undervoltage on the positive rail or on the negative rail;
- overvoltage;
- actuator over-speed;
- loss of the periodic reference clock (nominally 100 kHz).

A missing-clock detector counts system-clock cycles between rising edges of the reference clock. It reports loss of the clock when the count reaches a timeout. The fault latch is set at power-up. It clears only on a rising edge of the enable request, which is the same edge that starts the amplifier.

Every asynchronous input passes through a two-flop synchronizer before use. A change at a port therefore shows on the outputs three system-clock edges later.

Top module: `amp_guard`

## Requirements
- R1: After system reset, `fault_n` is 0 (fault latched) and `run_en` is 0.
- R2: While the synchronized enable request is low, `run_en` is 0 from the next cycle on.
- R3: A rising edge of `enable_req` with no fault condition present sets `fault_n` to 1 and `run_en` to 1 three cycles after the edge reaches the port. `run_en` never rises without such an edge.
- R4: Any one of these conditions latches a fault (`fault_n`=0) and drops `run_en` in the same cycle: `host_rst_n` low, `uv_pos` high, `uv_neg` high, `over_volt` high, `over_speed` high.
- R5: A latched fault stays latched after its condition goes away. It is cleared only by a later rising edge of `enable_req`. Holding `enable_req` high does not clear it.
- R6: If a fault condition is present during the enable rising edge, the fault wins: `fault_n` stays 0 and `run_en` stays 0.
- R7: When `ref_clk` shows no rising edge for `TIMEOUT_CYC` system cycles (default 1000), a no-clock fault latches. A reference clock toggling every 250 cycles causes no fault.
- R8: `run_en` is never 1 while `fault_n` is 0.
- R9: Once running, `run_en` stays 1 for as long as `enable_req` stays high and no fault condition appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| enable_req | input | 1 | Amplifier enable request from the servo controller |
| host_rst_n | input | 1 | Active-low processor reset; low is a fault condition |
| uv_pos | input | 1 | Positive rail undervoltage |
| uv_neg | input | 1 | Negative rail undervoltage |
| over_volt | input | 1 | Overvoltage |
| over_speed | input | 1 | Actuator over-speed |
| ref_clk | input | 1 | Reference clock watched for loss |
| fault_n | output | 1 | Latched fault flag, active low |
| run_en | output | 1 | Amplifier run enable |

## Verification
The hardest situation to reach from the ports is a loss of the reference clock. The bench drives `ref_clk` from a gated toggler. It stops the toggler for longer than the timeout and then restarts it. This shows that the fault stays latched after the clock returns until a fresh enable edge. A second case is a fault condition held across the enable rising edge. The bench raises a source first, then pulses the request, then removes the source, and confirms that the amplifier never starts.

// File: rtl/amp_guard_pkg.sv
package amp_guard_pkg;

  typedef struct packed {
    logic host_rst_n;
    logic uv_pos;
    logic uv_neg;
    logic over_volt;
    logic over_speed;
  } sense_t;

  localparam int SENSE_W = $bits(sense_t);

  // Combined fault condition from the synchronized sense inputs and the clock monitor
  function automatic logic fault_cond(sense_t s, logic no_clk);
    return (~s.host_rst_n) | s.uv_pos | s.uv_neg | s.over_volt | s.over_speed | no_clk;
  endfunction

  // Rising edge of a level given its current and previous value
  function automatic logic rise(logic now, logic prev);
    return now & ~prev;
  endfunction

endpackage

// File: rtl/amp_sync.sv
module amp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/amp_clk_monitor.sv
module amp_clk_monitor #(
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_s,
  output logic ref_edge,
  output logic no_clk
);
  import amp_guard_pkg::*;

  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

  logic          ref_d;
  logic [CW-1:0] cnt;

  assign ref_edge = rise(ref_s, ref_d);
  assign no_clk   = (cnt == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_d <= 1'b0;
      cnt   <= '0;
    end else begin
      ref_d <= ref_s;
      if (ref_edge)          cnt <= '0;
      else if (cnt != LIMIT) cnt <= cnt + 1'b1;
    end
  end

  p_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == LIMIT - 1'b1 && !ref_edge) |=> no_clk);
  p_edge_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_edge |=> !no_clk);
endmodule

// File: rtl/amp_fault_latch.sv
module amp_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic en_s,
  input  logic fault_set,
  output logic en_rise,
  output logic flt_q,
  output logic run_q
);
  import amp_guard_pkg::*;

  logic en_d;

  assign en_rise = rise(en_s, en_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d  <= 1'b0;
      flt_q <= 1'b1;
      run_q <= 1'b0;
    end else begin
      en_d <= en_s;
      if (fault_set)    flt_q <= 1'b1;
      else if (en_rise) flt_q <= 1'b0;
      if (!en_s || fault_set) run_q <= 1'b0;
      else if (en_rise)       run_q <= 1'b1;
    end
  end

  p_idle_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> !run_q);
  p_start_needs_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(en_rise));
  p_fault_latches_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_set |=> (flt_q && !run_q));
  p_clear_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flt_q) |-> $past(en_rise && !fault_set));
  p_fault_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && fault_set) |=> (flt_q && !run_q));
  p_run_excl_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> !flt_q);
  p_hold_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && en_s && !fault_set) |=> run_q);
endmodule

// File: rtl/amp_guard.sv
module amp_guard #(
  parameter int TIMEOUT_CYC = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_req,
  input  logic host_rst_n,
  input  logic uv_pos,
  input  logic uv_neg,
  input  logic over_volt,
  input  logic over_speed,
  input  logic ref_clk,
  output logic fault_n,
  output logic run_en
);
  import amp_guard_pkg::*;

  localparam int IN_W = SENSE_W + 2;

  logic [IN_W-1:0] raw, synced;
  sense_t          sense_s;
  logic            en_s, ref_s;
  logic            ref_edge, no_clk;
  logic            fault_set, en_rise, flt_q, run_q;

  assign raw = {ref_clk, enable_req, host_rst_n, uv_pos, uv_neg, over_volt, over_speed};

  amp_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  assign ref_s   = synced[IN_W-1];
  assign en_s    = synced[IN_W-2];
  assign sense_s = sense_t'(synced[SENSE_W-1:0]);

  amp_clk_monitor #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_mon (
    .clk(clk), .rst_n(rst_n), .ref_s(ref_s), .ref_edge(ref_edge), .no_clk(no_clk)
  );

  assign fault_set = fault_cond(sense_s, no_clk);

  amp_fault_latch u_latch (
    .clk(clk), .rst_n(rst_n), .en_s(en_s), .fault_set(fault_set),
    .en_rise(en_rise), .flt_q(flt_q), .run_q(run_q)
  );

  assign fault_n = ~flt_q;
  assign run_en  = run_q;

  p_outputs_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_en && !fault_n));
  p_noclk_faults_r7: assert property (@(posedge clk) disable iff (!rst_n)
    no_clk |=> !fault_n);
endmodule

// File: tb/tb_amp_guard.sv
module tb_amp_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable_req = 1'b0, host_rst_n = 1'b1, uv_pos = 1'b0, uv_neg = 1'b0;
  logic over_volt = 1'b0, over_speed = 1'b0, ref_clk = 1'b0, ref_run = 1'b1;
  logic fault_n, run_en;
  int vectors = 0, miscompares = 0;

  always #10 clk = ~clk;

  amp_guard dut (
    .clk(clk), .rst_n(rst_n), .enable_req(enable_req), .host_rst_n(host_rst_n),
    .uv_pos(uv_pos), .uv_neg(uv_neg), .over_volt(over_volt), .over_speed(over_speed),
    .ref_clk(ref_clk), .fault_n(fault_n), .run_en(run_en)
  );

  // Reference clock: toggles every 250 system cycles while enabled
  initial forever begin
    repeat (250) @(negedge clk);
    if (ref_run) ref_clk = ~ref_clk;
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic start_amp();
    enable_req = 1'b0; wait_cyc(4);
    enable_req = 1'b1; wait_cyc(4);
  endtask

  task automatic t_reset();
    wait_cyc(1);
    chk("R1 fault_n", fault_n, 1'b0);
    chk("R1 run_en", run_en, 1'b0);
    rst_n = 1'b1;
    wait_cyc(6);
    chk("R1 fault held after reset", fault_n, 1'b0);
  endtask

  task automatic t_start_hold();
    start_amp();
    chk("R3 fault cleared", fault_n, 1'b1);
    chk("R3 run started", run_en, 1'b1);
    wait_cyc(1200);
    chk("R9 still running", run_en, 1'b1);
    chk("R7 nominal ref no fault", fault_n, 1'b1);
    enable_req = 1'b0; wait_cyc(4);
    chk("R2 off when request low", run_en, 1'b0);
    chk("R2 no fault from request drop", fault_n, 1'b1);
  endtask

  task automatic t_source(string name, int which);
    start_amp();
    chk({"R4 pre ", name}, run_en, 1'b1);
    case (which)
      0: host_rst_n = 1'b0;
      1: uv_pos = 1'b1;
      2: uv_neg = 1'b1;
      3: over_volt = 1'b1;
      default: over_speed = 1'b1;
    endcase
    wait_cyc(2);
    host_rst_n = 1'b1; uv_pos = 1'b0; uv_neg = 1'b0; over_volt = 1'b0; over_speed = 1'b0;
    wait_cyc(3);
    chk({"R4 fault ", name}, fault_n, 1'b0);
    chk({"R4 run drop ", name}, run_en, 1'b0);
    wait_cyc(10);
    chk({"R5 sticky ", name}, fault_n, 1'b0);
    chk({"R8 no run ", name}, run_en, 1'b0);
  endtask

  task automatic t_fault_wins();
    enable_req = 1'b0; wait_cyc(4);
    over_volt = 1'b1; wait_cyc(4);
    enable_req = 1'b1; wait_cyc(4);
    chk("R6 fault kept", fault_n, 1'b0);
    chk("R6 run off", run_en, 1'b0);
    over_volt = 1'b0; wait_cyc(8);
    chk("R5 no clear while held high", fault_n, 1'b0);
    chk("R5 no start while held high", run_en, 1'b0);
    start_amp();
    chk("R5 cleared by new edge", fault_n, 1'b1);
    chk("R3 restarted", run_en, 1'b1);
  endtask

  task automatic t_no_clock();
    start_amp();
    wait (ref_clk == 1'b0);
    ref_run = 1'b0;
    wait_cyc(1600);
    chk("R7 no-clock fault", fault_n, 1'b0);
    chk("R7 run dropped", run_en, 1'b0);
    ref_run = 1'b1;
    wait_cyc(600);
    chk("R5 stays latched after clock returns", fault_n, 1'b0);
    start_amp();
    chk("R7 recovered after edge", fault_n, 1'b1);
    chk("R3 running after recovery", run_en, 1'b1);
    enable_req = 1'b0; wait_cyc(4);
  endtask

  initial begin
    t_reset();
    t_start_hold();
    t_source("host_rst", 0);
    t_source("uv_pos", 1);
    t_source("uv_neg", 2);
    t_source("ovolt", 3);
    t_source("ospeed", 4);
    t_fault_wins();
    t_no_clock();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule